// File: doc/BRIEF.md
# Trace Value Nibble Serializer

This block sits between a processor core and an external debug probe. The core hands it 32-bit trace values, such as the destination of a taken branch whose address came from a register, or a selected operand. The block queues them in a two-entry first-in first-out store. It then shifts each value out on a 4-bit debug data port, one nibble per clock, lowest nibble first. A 4-bit execution status code from the core is registered and sent out next to the data nibble. It travels its own one-cycle path and is never tied to the value being shifted out.

Captures use a valid/stall handshake. The core raises `cap_valid` with `cap_data`. The value is taken at the clock edge when `cap_valid` is high and `cap_stall` is low. While `cap_stall` is high the core must hold its value, and any capture offered in that cycle is not stored. The debug port has no back-pressure: once an entry reaches the head, its eight nibbles go out on eight consecutive clocks.

Top module: `trace_nibble_port`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both entries, the nibble index and the status register. After reset, `dbg_nib`, `stat_out` and `cap_stall` are all 0.
- R2: While the store is empty, `dbg_nib` is 0x0 and the nibble index stays at 0, so the next value starts at its lowest nibble.
- R3: A capture offered while at least one entry is free is accepted at that edge, with `cap_stall` low.
- R4: A value at the head is shown on `dbg_nib` for eight consecutive cycles. In cycle k (k = 0..7) the port shows bits [4k+3:4k]. The first nibble appears in the cycle after the value is accepted into an empty store.
- R5: Values leave in the order they were accepted.
- R6: `cap_stall` is high exactly when both entries hold data and the head is not on its last nibble (k = 7).
- R7: A capture offered in the cycle where the head's last nibble is shown is accepted without a stall, even though both entries are full.
- R8: A capture offered while `cap_stall` is high is not stored and does not disturb the stream on `dbg_nib`.
- R9: `stat_out` equals the `stat_in` of the previous cycle, whatever the data path is doing. Status codes such as 0x5 (taken branch begins) pass through unchanged.
- R10: When the second entry is waiting, its first nibble follows the head's last nibble in the very next cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the trace clock, one nibble per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cap_valid | input | 1 | Core offers a trace value |
| cap_data | input | 32 | Trace value offered |
| cap_stall | output | 1 | Back-pressure to the core; capture not taken while high |
| stat_in | input | 4 | Execution status code from the core |
| stat_out | output | 4 | Registered status code to the debug port |
| dbg_nib | output | 4 | Debug data nibble, 0x0 when idle |

## Verification
The bench builds the block with its default parameters: 32-bit values, 4-bit nibbles and two entries. With only two entries, a short burst of captures fills the store. This quickly reaches the full-store stall, the capture on the last-nibble cycle and dropped captures under stall. Because the status path is fed with every code, including 0x5, while the data path is busy, any coupling between the two outputs would show up at once.

// File: rtl/trace_pkg.sv
package trace_pkg;
  parameter int unsigned TRC_VAL_W  = 32;
  parameter int unsigned TRC_NIB_W  = 4;
  parameter int unsigned TRC_DEPTH  = 2;
  parameter int unsigned TRC_STAT_W = 4;
endpackage

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         head_valid,
  output logic         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (push) begin
        slot[wr_ptr] <= wdata;
        wr_ptr       <= nxt(wr_ptr);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign head       = slot[rd_ptr];
  assign head_valid = (fill != '0);
  assign full       = (fill == CNT_W'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |-> pop);

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);
endmodule

// File: rtl/trace_nib_ser.sv
module trace_nib_ser #(
  parameter int unsigned W     = 32,
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     head,
  input  logic             head_valid,
  output logic             pop,
  output logic             last,
  output logic [NIB_W-1:0] nib
);
  localparam int unsigned NIBS  = W / NIB_W;
  localparam int unsigned IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst)                     idx <= '0;
    else if (!head_valid || last) idx <= '0;
    else                         idx <= idx + IDX_W'(1);
  end

  assign last = head_valid && (idx == LAST_IDX);
  assign pop  = last;
  assign nib  = head_valid ? head[idx*NIB_W +: NIB_W] : '0;

  // R2
  idle_index_chk: assert property (@(posedge clk) disable iff (rst)
    !head_valid |=> idx == '0);

  // R4
  index_step_chk: assert property (@(posedge clk) disable iff (rst)
    (head_valid && idx != LAST_IDX) |=> idx == $past(idx) + IDX_W'(1));

  // R10
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (head_valid && idx != '0) |-> $past(head_valid));
endmodule

// File: rtl/trace_nibble_port.sv
module trace_nibble_port
  import trace_pkg::*;
#(
  parameter int unsigned VAL_W  = TRC_VAL_W,
  parameter int unsigned NIB_W  = TRC_NIB_W,
  parameter int unsigned DEPTH  = TRC_DEPTH,
  parameter int unsigned STAT_W = TRC_STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [VAL_W-1:0]  cap_data,
  output logic              cap_stall,
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] stat_out,
  output logic [NIB_W-1:0]  dbg_nib
);
  logic [VAL_W-1:0] head;
  logic             head_valid, full, pop, last, push;

  assign cap_stall = full && !last;
  assign push      = cap_valid && !cap_stall;

  trace_fifo #(.W(VAL_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(cap_data), .pop(pop),
    .head(head), .head_valid(head_valid), .full(full)
  );

  trace_nib_ser #(.W(VAL_W), .NIB_W(NIB_W)) u_ser (
    .clk(clk), .rst(rst), .head(head), .head_valid(head_valid),
    .pop(pop), .last(last), .nib(dbg_nib)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_out <= '0;
    else     stat_out <= stat_in;
  end

  // R6
  stall_full_chk: assert property (@(posedge clk) disable iff (rst)
    cap_stall |-> full);

  // R9
  status_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stat_out == $past(stat_in));

  // R7
  last_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && pop) |-> push);
endmodule

// File: tb/tb_trace_nibble_port.sv
module tb_trace_nibble_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_data = '0;
  logic        cap_stall;
  logic [3:0]  stat_in = '0;
  logic [3:0]  stat_out;
  logic [3:0]  dbg_nib;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] q[$];
  int          idx = 0;
  logic [3:0]  st_prev = '0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk;

  trace_nibble_port dut (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_stall(cap_stall), .stat_in(stat_in), .stat_out(stat_out),
    .dbg_nib(dbg_nib)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] d, input logic [3:0] st);
    bit stall_e, last_e, push_e;
    logic [3:0] dd_e;
    @(negedge clk);
    cap_valid = v; cap_data = d; stat_in = st;
    #1;
    last_e  = (q.size() > 0) && (idx == 7);
    stall_e = (q.size() == 2) && !last_e;
    dd_e    = (q.size() > 0) ? q[0][idx*4 +: 4] : 4'h0;
    if (q.size() == 0)      check("R2 dbg_nib idle", 32'(dbg_nib), 32'(dd_e));
    else                    check("R4 R5 R10 dbg_nib", 32'(dbg_nib), 32'(dd_e));
    if (q.size() < 2)       check("R3 cap_stall", 32'(cap_stall), 32'(stall_e));
    else if (last_e)        check("R7 cap_stall", 32'(cap_stall), 32'(stall_e));
    else                    check("R6 R8 cap_stall", 32'(cap_stall), 32'(stall_e));
    check("R9 stat_out", 32'(stat_out), 32'(st_prev));
    push_e = v && !stall_e;
    if (q.size() > 0) idx = last_e ? 0 : idx + 1; else idx = 0;
    if (last_e) void'(q.pop_front());
    if (push_e) q.push_back(d);
    st_prev = st;
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 dbg_nib", 32'(dbg_nib), 32'h0);
    check("R1 stat_out", 32'(stat_out), 32'h0);
    check("R1 cap_stall", 32'(cap_stall), 32'h0);
    // R2 idle, R9 status including 0x5
    for (int i = 0; i < 16; i++) step(0, 32'hFFFF_FFFF, 4'(i));
    // R4 single value, lowest nibble first
    step(1, 32'h8765_4321, 4'h5);
    for (int i = 0; i < 10; i++) step(0, '0, 4'h1);
    // R5 R10 back-to-back values
    step(1, 32'hDEAD_BEEF, 4'h5);
    step(1, 32'h0123_4567, 4'h2);
    for (int i = 0; i < 18; i++) step(0, '0, 4'h0);
    // R6 R8 fill then offer while stalled; R7 accept on last nibble
    step(1, 32'hAAAA_5555, 4'h5);
    step(1, 32'h1357_9BDF, 4'h3);
    for (int i = 0; i < 10; i++) step(1, 32'hC0DE_0000 | 32'(i), 4'(i));
    for (int i = 0; i < 30; i++) step(0, '0, 4'h0);
    // continuous offers with mixed patterns
    for (int i = 0; i < 300; i++) step(rnd() % 3 != 0, rnd(), rnd() % 16);
    for (int i = 0; i < 30; i++) step(0, '0, 4'h5);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule